// File: doc/BRIEF.md
# Mode-Gated Register Transfer Unit

This unit executes the supplementary register-transfer operations of a 60-bit word machine that runs in either an unprivileged problem mode or a privileged monitor mode. It holds four banks: eight working X registers, eight scratch T registers, breakpoint P registers (eight addresses, six implemented) and eight debug C registers. Each 15-bit instruction is split into four octal fields. The unit classifies the instruction against the current mode and then does one of four things: performs a copy or a ones' complement add, signals a program stop, flags an illegal operation, or marks a floating-point opcode as cleared for dispatch.

The surrounding CPU presents one instruction per `valid` pulse, together with the mode bit. For the memory-add operation it also supplies the memory word that has already been fetched. X registers are filled through a load port and observed through a combinational read port. Instruction fetch, address generation and the floating-point arithmetic itself are handled elsewhere.

Top module: `modereg_xfer_unit`

## Requirements
- R1: After reset every register in all four banks reads zero and the outputs `done`, `stop`, `illegal_op` and `fp_ok` are low.
- R2: The instruction fields are fm = instr[14:9], i = instr[8:6], j = instr[5:3] and k = instr[2:0]. The 9-bit opcode is {fm,i}, written in octal. In monitor mode, opcode 001 copies Xk to Cj, 002 copies Ck to Xj, 005 copies Xk to Tj and 006 copies Tk to Xj. Each of these raises `done`.
- R3: In monitor mode, opcode 003 copies Xk to Pj and opcode 004 copies Pk to Xj. A write to P6 or P7 is dropped, and a read of P6 or P7 yields zero.
- R4: Opcode 000 raises `stop` in both modes. In problem mode, opcodes 001 to 006 also raise `stop` and leave every register unchanged.
- R5: Opcode 016, in either mode, replaces Xj with the 60-bit ones' complement sum of Xj and Tk: the carry out of bit 59 is added back in at bit 0. It raises `done`.
- R6: In problem mode, opcode 017 replaces Xj with the ones' complement sum of Xj and `mem_data` and raises `done`. In monitor mode it raises `illegal_op` and changes no register.
- R7: An instruction whose fm field is octal 30 to 35 (add or subtract) or 44 to 45 (divide) raises `illegal_op` in monitor mode and `fp_ok` in problem mode. An fm of octal 40 to 42 (multiply) raises `fp_ok` in both modes. No register changes in any of these cases.
- R8: Each flag is a single-cycle pulse in the cycle after `valid`, and at most one flag is high at a time. Any opcode not named in R2 to R7 raises no flag and changes no register.
- R9: When `ld_en` is high, X[`ld_idx`] takes `ld_data` at the clock edge. `x_rd_data` always shows X[`x_rd_idx`].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Instruction present this cycle |
| monitor | input | 1 | 1 = monitor mode, 0 = problem mode |
| instr | input | 15 | Instruction word |
| mem_data | input | 60 | Fetched memory word for opcode 017 |
| ld_en | input | 1 | X register load enable |
| ld_idx | input | 3 | X register load index |
| ld_data | input | 60 | X register load value |
| x_rd_idx | input | 3 | X register read index |
| x_rd_data | output | 60 | X register read value |
| done | output | 1 | Transfer or add executed |
| stop | output | 1 | Program stop |
| illegal_op | output | 1 | Instruction prohibited in the current mode |
| fp_ok | output | 1 | Floating-point opcode cleared for dispatch |

## Verification
A decode error or a wrongly gated write enable shows up on the status flags in the first cycle after the instruction. A problem-mode transfer that is wrongly accepted raises `done` instead of `stop`. Corruption of a privileged bank appears only when that bank is next copied into an X register: a stray T write is caught by a later problem-mode 016 add, and a stray P write by a later 004 read. Wrong carry handling is checked with operands chosen so that the end-around carry fires, including a negative-zero operand.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  localparam int WORD_W  = 60;
  localparam int INSTR_W = 15;
  localparam int FIELD_W = 3;
  localparam int FM_W    = 6;
  localparam int OP_W    = FM_W + FIELD_W;

  typedef enum logic [3:0] {
    CLS_NONE, CLS_STOP, CLS_ILLEGAL, CLS_FP,
    CLS_X2C, CLS_C2X, CLS_X2P, CLS_P2X,
    CLS_X2T, CLS_T2X, CLS_ADDT, CLS_ADDM
  } op_class_e;

  // ones' complement sum with end-around carry
  function automatic logic [WORD_W-1:0] oc_add(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b);
    logic [WORD_W:0] raw;
    raw = {1'b0, a} + {1'b0, b};
    return raw[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, raw[WORD_W]};
  endfunction

  // fm codes that monitor mode may not issue (add/sub/divide)
  function automatic logic fm_fp_restricted(input logic [FM_W-1:0] fm);
    return (fm >= 6'o30 && fm <= 6'o35) || fm == 6'o44 || fm == 6'o45;
  endfunction

  // fm codes allowed in both modes (multiply)
  function automatic logic fm_fp_free(input logic [FM_W-1:0] fm);
    return fm >= 6'o40 && fm <= 6'o42;
  endfunction
endpackage

// File: rtl/mrx_decode.sv
module mrx_decode
  import mrx_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic               monitor,
  output op_class_e          cls,
  output logic [FIELD_W-1:0] fj,
  output logic [FIELD_W-1:0] fk
);
  logic [FM_W-1:0] fm;
  logic [OP_W-1:0] op;

  assign fm = instr[INSTR_W-1 -: FM_W];
  assign op = instr[INSTR_W-1 -: OP_W];
  assign fj = instr[2*FIELD_W-1 -: FIELD_W];
  assign fk = instr[FIELD_W-1:0];

  always_comb begin
    cls = CLS_NONE;
    if (op == 9'o000) begin
      cls = CLS_STOP;
    end else if (op >= 9'o001 && op <= 9'o006) begin
      if (!monitor) begin
        cls = CLS_STOP;
      end else begin
        unique case (op)
          9'o001:  cls = CLS_X2C;
          9'o002:  cls = CLS_C2X;
          9'o003:  cls = CLS_X2P;
          9'o004:  cls = CLS_P2X;
          9'o005:  cls = CLS_X2T;
          default: cls = CLS_T2X;
        endcase
      end
    end else if (op == 9'o016) begin
      cls = CLS_ADDT;
    end else if (op == 9'o017) begin
      cls = monitor ? CLS_ILLEGAL : CLS_ADDM;
    end else if (fm_fp_restricted(fm)) begin
      cls = monitor ? CLS_ILLEGAL : CLS_FP;
    end else if (fm_fp_free(fm)) begin
      cls = CLS_FP;
    end
  end
endmodule

// File: rtl/mrx_bank.sv
module mrx_bank #(
  parameter int W     = 60,
  parameter int DEPTH = 8,
  parameter int IMPL  = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IW-1:0]             widx,
  input  logic [W-1:0]              wdata,
  output logic [DEPTH-1:0][W-1:0]   q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (g < IMPL) begin : g_real
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n)                         r <= '0;
        else if (we && widx == IW'(g))      r <= wdata;
      end
      assign q[g] = r;
    end else begin : g_absent
      assign q[g] = '0;
    end
  end
endmodule

// File: rtl/modereg_xfer_unit.sv
module modereg_xfer_unit
  import mrx_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int P_IMPL = 6,
  localparam int IW    = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic                monitor,
  input  logic [14:0]         instr,
  input  logic [59:0]         mem_data,
  input  logic                ld_en,
  input  logic [2:0]          ld_idx,
  input  logic [59:0]         ld_data,
  input  logic [2:0]          x_rd_idx,
  output logic [59:0]         x_rd_data,
  output logic                done,
  output logic                stop,
  output logic                illegal_op,
  output logic                fp_ok
);
  op_class_e          cls;
  logic [FIELD_W-1:0] fj, fk;

  mrx_decode u_dec (.instr(instr), .monitor(monitor), .cls(cls), .fj(fj), .fk(fk));

  logic [NREG-1:0][WORD_W-1:0] xq, tq, pq, cq;
  logic              x_we, t_we, p_we, c_we, x_wr_instr;
  logic [IW-1:0]     x_widx, p_widx;
  logic [WORD_W-1:0] x_wdata, x_instr_data;
  logic [WORD_W-1:0] xj, xk;
  logic              ev_done, ev_stop, ev_illegal, ev_fp;

  assign xj = xq[fj];
  assign xk = xq[fk];

  // X results from instructions
  always_comb begin
    x_wr_instr   = 1'b0;
    x_instr_data = '0;
    if (valid) begin
      unique case (cls)
        CLS_C2X:  begin x_wr_instr = 1'b1; x_instr_data = cq[fk]; end
        CLS_P2X:  begin x_wr_instr = 1'b1; x_instr_data = pq[fk]; end
        CLS_T2X:  begin x_wr_instr = 1'b1; x_instr_data = tq[fk]; end
        CLS_ADDT: begin x_wr_instr = 1'b1; x_instr_data = oc_add(xj, tq[fk]); end
        CLS_ADDM: begin x_wr_instr = 1'b1; x_instr_data = oc_add(xj, mem_data); end
        default:  ;
      endcase
    end
  end

  // instruction write wins over the load port
  assign x_we    = x_wr_instr | ld_en;
  assign x_widx  = x_wr_instr ? fj : ld_idx;
  assign x_wdata = x_wr_instr ? x_instr_data : ld_data;

  assign t_we   = valid && cls == CLS_X2T;
  assign c_we   = valid && cls == CLS_X2C;
  assign p_we   = valid && cls == CLS_X2P && fj < FIELD_W'(P_IMPL);
  assign p_widx = fj;

  mrx_bank #(.W(WORD_W), .DEPTH(NREG), .IMPL(NREG)) u_xbank
    (.clk(clk), .rst_n(rst_n), .we(x_we), .widx(x_widx), .wdata(x_wdata), .q(xq));
  mrx_bank #(.W(WORD_W), .DEPTH(NREG), .IMPL(NREG)) u_tbank
    (.clk(clk), .rst_n(rst_n), .we(t_we), .widx(fj), .wdata(xk), .q(tq));
  mrx_bank #(.W(WORD_W), .DEPTH(NREG), .IMPL(P_IMPL)) u_pbank
    (.clk(clk), .rst_n(rst_n), .we(p_we), .widx(p_widx), .wdata(xk), .q(pq));
  mrx_bank #(.W(WORD_W), .DEPTH(NREG), .IMPL(NREG)) u_cbank
    (.clk(clk), .rst_n(rst_n), .we(c_we), .widx(fj), .wdata(xk), .q(cq));

  assign x_rd_data = xq[x_rd_idx];

  // named events for status
  assign ev_stop    = valid && cls == CLS_STOP;
  assign ev_illegal = valid && cls == CLS_ILLEGAL;
  assign ev_fp      = valid && cls == CLS_FP;
  assign ev_done    = valid && (x_wr_instr || t_we || c_we || cls == CLS_X2P);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0; stop <= 1'b0; illegal_op <= 1'b0; fp_ok <= 1'b0;
    end else begin
      done <= ev_done; stop <= ev_stop; illegal_op <= ev_illegal; fp_ok <= ev_fp;
    end
  end
endmodule

// File: rtl/mrx_checker.sv
module mrx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        valid,
  input logic        monitor,
  input logic [14:0] instr,
  input logic        done,
  input logic        stop,
  input logic        illegal_op,
  input logic        fp_ok,
  input logic        x_wr_instr,
  input logic        t_we,
  input logic        p_we,
  input logic        c_we,
  input logic [2:0]  p_widx
);
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, stop, illegal_op, fp_ok})); // R8
  AST_FLAG_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    valid == 1'b0 |=> !(done || stop || illegal_op || fp_ok)); // R8
  AST_PROBLEM_NO_PRIV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !monitor) |-> !(t_we || p_we || c_we)); // R4
  AST_P_HIGH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    p_we |-> p_widx < 3'd6); // R3
  AST_MON_FP_PROHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && monitor && ((instr[14:9] >= 6'o30 && instr[14:9] <= 6'o35) ||
     instr[14:9] == 6'o44 || instr[14:9] == 6'o45)) |=> illegal_op); // R7
  AST_ILLEGAL_NO_X_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && monitor && instr[14:6] == 9'o017) |-> !x_wr_instr); // R6
endmodule

bind modereg_xfer_unit mrx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .monitor(monitor), .instr(instr),
  .done(done), .stop(stop), .illegal_op(illegal_op), .fp_ok(fp_ok),
  .x_wr_instr(x_wr_instr), .t_we(t_we), .p_we(p_we), .c_we(c_we), .p_widx(p_widx)
);

// File: tb/test_modereg_xfer_unit.sv
module test_modereg_xfer_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, valid = 1'b0, monitor = 1'b0, ld_en = 1'b0;
  logic [14:0] instr = '0;
  logic [59:0] mem_data = '0, ld_data = '0, x_rd_data;
  logic [2:0]  ld_idx = '0, x_rd_idx = '0;
  logic        done, stop, illegal_op, fp_ok;

  modereg_xfer_unit i_modereg_xfer_unit (
    .clk(clk), .rst_n(rst_n), .valid(valid), .monitor(monitor), .instr(instr),
    .mem_data(mem_data), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .x_rd_idx(x_rd_idx), .x_rd_data(x_rd_data), .done(done), .stop(stop),
    .illegal_op(illegal_op), .fp_ok(fp_ok));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [59:0] xm [8], tm [8], pm [8], cm [8];
  logic [3:0]  exp_q [$];   // {done,stop,illegal,fp_ok}
  string       tag_q [$];
  logic        issued = 1'b0;

  localparam logic [59:0] ALL1 = {60{1'b1}};

  // adds the wrap-around of 2^60 - 1 back in a different form
  function automatic logic [59:0] ref_add(logic [59:0] a, logic [59:0] b);
    logic [63:0] s;
    s = {4'b0, a} + {4'b0, b};
    if (s > {4'b0, ALL1}) s = s - {4'b0, ALL1};
    return s[59:0];
  endfunction

  function automatic logic [14:0] mk(logic [8:0] op, logic [2:0] j, logic [2:0] k);
    return {op, j, k};
  endfunction

  task automatic check(string req, logic [59:0] act, logic [59:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: updates the bench model and pushes expected flags
  task automatic issue(logic mon, logic [14:0] ins, logic [59:0] mem, string tag);
    logic [8:0] op; logic [5:0] fm; logic [2:0] j, k; logic [3:0] e;
    op = ins[14:6]; fm = ins[14:9]; j = ins[5:3]; k = ins[2:0]; e = 4'b0000;
    if (op == 9'o000) e = 4'b0100;
    else if (op >= 9'o001 && op <= 9'o006) begin
      if (!mon) e = 4'b0100;
      else begin
        e = 4'b1000;
        case (op)
          9'o001: cm[j] = xm[k];
          9'o002: xm[j] = cm[k];
          9'o003: if (j < 6) pm[j] = xm[k];
          9'o004: xm[j] = (k < 6) ? pm[k] : '0;
          9'o005: tm[j] = xm[k];
          default: xm[j] = tm[k];
        endcase
      end
    end else if (op == 9'o016) begin e = 4'b1000; xm[j] = ref_add(xm[j], tm[k]); end
    else if (op == 9'o017) begin
      if (mon) e = 4'b0010; else begin e = 4'b1000; xm[j] = ref_add(xm[j], mem); end
    end else if (fm inside {6'o30, 6'o31, 6'o32, 6'o33, 6'o34, 6'o35, 6'o44, 6'o45})
      e = mon ? 4'b0010 : 4'b0001;
    else if (fm inside {6'o40, 6'o41, 6'o42}) e = 4'b0001;
    @(posedge clk); #1;
    valid = 1'b1; monitor = mon; instr = ins; mem_data = mem;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    valid = 1'b0;
  endtask

  task automatic load(logic [2:0] idx, logic [59:0] v);
    @(posedge clk); #1;
    ld_en = 1'b1; ld_idx = idx; ld_data = v; xm[idx] = v;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  task automatic chk_x(logic [2:0] idx, string req);
    @(negedge clk);
    x_rd_idx = idx; #1;
    check(req, x_rd_data, xm[idx]);
  endtask

  // monitor: compares flags one cycle after each issued instruction
  always @(posedge clk) issued <= valid;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (issued) begin
        if (exp_q.size() == 0) check("R8 unexpected", 60'd1, 60'd0);
        else begin
          logic [3:0] e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(t, {56'd0, done, stop, illegal_op, fp_ok}, {56'd0, e});
        end
      end else begin
        check("R8 idle flags", {56'd0, done, stop, illegal_op, fp_ok}, 60'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 8; r++) begin xm[r] = '0; tm[r] = '0; pm[r] = '0; cm[r] = '0; end
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R1 reset state
    check("R1 flags", {56'd0, done, stop, illegal_op, fp_ok}, 60'd0);
    for (int r = 0; r < 8; r++) chk_x(3'(r), "R1 X zero");
    // R9 load port
    load(1, 60'd5); load(2, 60'h0FF_0123_4567_89AB); load(3, ALL1 - 60'd1);
    load(4, 60'd3); load(7, 60'd9); load(6, ALL1);
    chk_x(2, "R9 load"); chk_x(7, "R9 load");
    // R2 monitor transfers
    issue(1, mk(9'o005, 2, 1), '0, "R2 X->T");
    issue(1, mk(9'o006, 5, 2), '0, "R2 T->X");
    chk_x(5, "R2 T2 to X5");
    issue(1, mk(9'o001, 3, 2), '0, "R2 X->C");
    issue(1, mk(9'o002, 0, 3), '0, "R2 C->X");
    chk_x(0, "R2 C3 to X0");
    // R3 P bank including absent entries
    issue(1, mk(9'o003, 6, 1), '0, "R3 P6 write");
    issue(1, mk(9'o004, 7, 6), '0, "R3 P6 read");
    chk_x(7, "R3 P6 reads zero");
    issue(1, mk(9'o003, 5, 4), '0, "R3 P5 write");
    issue(1, mk(9'o004, 0, 5), '0, "R3 P5 read");
    chk_x(0, "R3 P5 to X0");
    // R4 stops
    issue(0, mk(9'o006, 1, 2), '0, "R4 problem 006");
    chk_x(1, "R4 X1 unchanged");
    issue(0, mk(9'o005, 2, 3), '0, "R4 problem 005");
    issue(0, mk(9'o001, 4, 4), '0, "R4 problem 001");
    issue(0, mk(9'o000, 0, 0), '0, "R4 problem 000");
    issue(1, mk(9'o000, 0, 0), '0, "R4 monitor 000");
    // R5 ones' complement add, T2 still 5 proves R4 left T alone
    issue(0, mk(9'o016, 3, 2), '0, "R5 -1 + 5");
    chk_x(3, "R5 end-around carry");
    issue(0, mk(9'o016, 6, 2), '0, "R5 -0 + 5");
    chk_x(6, "R5 negative zero");
    issue(1, mk(9'o016, 4, 2), '0, "R5 monitor add");
    chk_x(4, "R5 3 + 5");
    // R6 memory add
    issue(0, mk(9'o017, 4, 0), 60'h123, "R6 problem 017");
    chk_x(4, "R6 X4 + mem");
    issue(1, mk(9'o017, 4, 0), 60'h777, "R6 monitor 017");
    chk_x(4, "R6 X4 unchanged");
    // R7 floating-point classification
    issue(1, {6'o30, 9'o0}, '0, "R7 mon fadd");
    issue(1, {6'o35, 9'o0}, '0, "R7 mon sub");
    issue(1, {6'o44, 9'o0}, '0, "R7 mon div");
    issue(1, {6'o40, 9'o0}, '0, "R7 mon mul");
    issue(0, {6'o31, 9'o0}, '0, "R7 prob sub");
    issue(0, {6'o45, 9'o0}, '0, "R7 prob div");
    issue(0, {6'o42, 9'o0}, '0, "R7 prob mul");
    // R8 unrelated opcodes
    issue(1, mk(9'o007, 1, 1), '0, "R8 op 007");
    issue(1, {6'o50, 3'd0, 3'd1, 3'd1}, '0, "R8 fm 50");
    chk_x(1, "R8 X1 unchanged");
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) check("R8 pending", 60'(exp_q.size()), 60'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule